// File: doc/BRIEF.md
# I2C Master Interrupt Status and Stall Unit

This block gathers the one-cycle event pulses raised by the bus engine and the FIFOs of a FIFO-based I2C master into a sticky status register. A separate enable register masks that status into a single interrupt line. Software acknowledges events by writing ones to a write-one-to-clear port.

While any status bit is pending, masked or not, the unit holds a stall line to the bus engine. The engine therefore waits until software has cleared every pending event. The receive-FIFO-full and receive-byte-count-reached events have separate bits. When the receive length is a multiple of the FIFO depth, the FIFO-full flag can rise a cycle or more before the byte-count flag. A failed address acknowledge on a read raises no receive-complete bit.

The I2C line handling and the register address decoding sit outside this block. The unit sees only the decoded write strobes and their data.

Top module: `i2c_irq_stall_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, status_o is 0, the enable register is 0, and irq_o and stall_o are 0.
- R2: An event pulse on evt_i[k] for an implemented bit k sets status_o[k] on the next clock edge, and the bit stays set until it is cleared. The implemented bit positions are: TX FIFO empty 9, RX FIFO full 8, send complete with STOP 7, receive complete with STOP 6, TX byte count reached 5, RX byte count reached 4, no ACK 2, arbitration lost 1.
- R3: A cycle with clr_wr_i high clears every status bit whose clr_data_i bit is 1, on the next edge. Status bits whose clr_data_i bit is 0 keep their value.
- R4: If an event and a clear hit the same bit in the same cycle, the bit is set after the edge.
- R5: irq_o is high exactly when some bit is set in both status_o and the enable register.
- R6: stall_o is high exactly when any status bit is set, whatever the enable register holds.
- R7: Bit positions 0 and 3 are reserved. They never set in status_o, and they cannot raise irq_o, even when an event arrives or an enable write sets those positions.
- R8: A cycle with en_wr_i high loads en_data_i into the enable register, using the same bit layout as status. The new mask applies to irq_o from the next edge.
- R9: RX FIFO full (bit 8) and RX byte count reached (bit 4) are independent. They are set in separate cycles, and clearing one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | One-cycle event pulses, one per status bit |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_data_i | input | 10 | New enable mask |
| clr_wr_i | input | 1 | Write strobe for the clear command |
| clr_data_i | input | 10 | Write-one-to-clear mask |
| status_o | output | 10 | Sticky status register |
| irq_o | output | 1 | Masked interrupt line |
| stall_o | output | 1 | Pause request to the bus engine |

## Verification
A vector table drives one event pulse at a time under a disabled and then an enabled mask. This separates the stall line, which follows raw status, from the interrupt line, which follows masked status. The receive-full and byte-count bits are raised in separate rows and cleared one at a time, so that a design that couples them is exposed. Further rows cover a collision of an event and a clear on one bit, and a clear mask that also covers bits that are not set. Reserved positions are pulsed with every enable bit set. A reset in the middle of a run confirms that all state returns to zero.

// File: rtl/irq_stall_pkg.sv
package irq_stall_pkg;
  localparam int STAT_W = 10;

  localparam int BIT_ARB_LOST = 1;
  localparam int BIT_NO_ACK   = 2;
  localparam int BIT_RX_CNT   = 4;
  localparam int BIT_TX_CNT   = 5;
  localparam int BIT_RX_STOP  = 6;
  localparam int BIT_TX_STOP  = 7;
  localparam int BIT_RX_FULL  = 8;
  localparam int BIT_TX_EMPTY = 9;

  localparam logic [STAT_W-1:0] VALID_MASK =
      (STAT_W'(1) << BIT_ARB_LOST) | (STAT_W'(1) << BIT_NO_ACK)  |
      (STAT_W'(1) << BIT_RX_CNT)   | (STAT_W'(1) << BIT_TX_CNT)  |
      (STAT_W'(1) << BIT_RX_STOP)  | (STAT_W'(1) << BIT_TX_STOP) |
      (STAT_W'(1) << BIT_RX_FULL)  | (STAT_W'(1) << BIT_TX_EMPTY);
endpackage

// File: rtl/irq_stat_bit.sv
module irq_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (evt_i) q_o <= 1'b1;   // event wins over clear
    else if (clr_i) q_o <= 1'b0;
  end

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> q_o);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !q_o);
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int                 WIDTH = 10,
  parameter logic [WIDTH-1:0]   MASK  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= data_i & MASK;
  end

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_o == ($past(data_i) & MASK)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] status_i,
  input  logic [WIDTH-1:0] en_i,
  output logic             irq_o,
  output logic             stall_o
);
  always_comb begin
    irq_o   = |(status_i & en_i);
    stall_o = |status_i;          // unmasked: disabled events still pause
  end
endmodule

// File: rtl/i2c_irq_stall_unit.sv
module i2c_irq_stall_unit
  import irq_stall_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              en_wr_i,
  input  logic [STAT_W-1:0] en_data_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              stall_o
);
  logic [STAT_W-1:0] en_q;
  logic [STAT_W-1:0] clr_vec;
  logic              unused_rsvd;

  assign clr_vec     = clr_wr_i ? clr_data_i : '0;
  assign unused_rsvd = ^((evt_i | clr_vec) & ~VALID_MASK);

  for (genvar k = 0; k < STAT_W; k++) begin : g_stat
    if (VALID_MASK[k]) begin : g_impl
      irq_stat_bit u_bit (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (evt_i[k]),
        .clr_i (clr_vec[k]),
        .q_o   (status_o[k])
      );
    end else begin : g_rsvd
      assign status_o[k] = 1'b0;
    end
  end

  irq_enable_reg #(.WIDTH(STAT_W), .MASK(VALID_MASK)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (en_wr_i),
    .data_i(en_data_i),
    .en_o  (en_q)
  );

  irq_combine #(.WIDTH(STAT_W)) u_comb (
    .status_i(status_o),
    .en_i    (en_q),
    .irq_o   (irq_o),
    .stall_o (stall_o)
  );

  p_evt_stalls_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & VALID_MASK)) |=> stall_o);
  p_mask_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && en_data_i == '0) |=> !irq_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && evt_i == '0) |=> !irq_o);
endmodule

// File: tb/tb_i2c_irq_stall_unit.sv
module tb_i2c_irq_stall_unit;
  localparam int W = 10;

  typedef struct packed {
    logic [W-1:0]  evt;
    logic          en_wr;
    logic [W-1:0]  en_d;
    logic          clr_wr;
    logic [W-1:0]  clr_d;
    logic [W-1:0]  exp_st;
    logic          exp_irq;
    logic          exp_stall;
    logic [15:0]   tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{10'h200, 1'b0, 10'h000, 1'b0, 10'h000, 10'h200, 1'b0, 1'b1, "R6"}, // masked event still stalls
    '{10'h000, 1'b1, 10'h200, 1'b0, 10'h000, 10'h200, 1'b1, 1'b1, "R8"},
    '{10'h000, 1'b0, 10'h000, 1'b1, 10'h200, 10'h000, 1'b0, 1'b0, "R3"},
    '{10'h100, 1'b0, 10'h000, 1'b0, 10'h000, 10'h100, 1'b0, 1'b1, "R9"},
    '{10'h000, 1'b0, 10'h000, 1'b0, 10'h000, 10'h100, 1'b0, 1'b1, "R2"}, // sticky
    '{10'h010, 1'b0, 10'h000, 1'b0, 10'h000, 10'h110, 1'b0, 1'b1, "R9"},
    '{10'h000, 1'b0, 10'h000, 1'b1, 10'h100, 10'h010, 1'b0, 1'b1, "R9"},
    '{10'h002, 1'b0, 10'h000, 1'b1, 10'h002, 10'h012, 1'b0, 1'b1, "R4"},
    '{10'h000, 1'b1, 10'h006, 1'b0, 10'h000, 10'h012, 1'b1, 1'b1, "R5"},
    '{10'h000, 1'b0, 10'h000, 1'b1, 10'h002, 10'h010, 1'b0, 1'b1, "R5"},
    '{10'h009, 1'b1, 10'h3FF, 1'b0, 10'h000, 10'h010, 1'b1, 1'b1, "R7"},
    '{10'h000, 1'b0, 10'h000, 1'b1, 10'h3FF, 10'h000, 1'b0, 1'b0, "R3"},
    '{10'h0C4, 1'b0, 10'h000, 1'b0, 10'h000, 10'h0C4, 1'b1, 1'b1, "R2"},
    '{10'h000, 1'b1, 10'h000, 1'b0, 10'h000, 10'h0C4, 1'b0, 1'b1, "R6"}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] evt_i = '0;
  logic         en_wr_i = 1'b0;
  logic [W-1:0] en_data_i = '0;
  logic         clr_wr_i = 1'b0;
  logic [W-1:0] clr_data_i = '0;
  logic [W-1:0] status_o;
  logic         irq_o;
  logic         stall_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  i2c_irq_stall_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
    .status_o(status_o), .irq_o(irq_o), .stall_o(stall_o)
  );

  task automatic check(input string req, input logic [W-1:0] st,
                       input logic irq, input logic stl);
    checks++;
    if (status_o !== st || irq_o !== irq || stall_o !== stl) begin
      errors++;
      $display("FAIL %s: status=%h irq=%b stall=%b, expected status=%h irq=%b stall=%b",
               req, status_o, irq_o, stall_o, st, irq, stl);
    end
  endtask

  task automatic drive(input logic [W-1:0] e, input logic ew, input logic [W-1:0] ed,
                       input logic cw, input logic [W-1:0] cd);
    evt_i = e; en_wr_i = ew; en_data_i = ed; clr_wr_i = cw; clr_data_i = cd;
    @(negedge clk_i);
    evt_i = '0; en_wr_i = 1'b0; en_data_i = '0; clr_wr_i = 1'b0; clr_data_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", '0, 1'b0, 1'b0);          // during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", '0, 1'b0, 1'b0);          // after release

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].evt, VECS[i].en_wr, VECS[i].en_d,
            VECS[i].clr_wr, VECS[i].clr_d);
      check(string'(VECS[i].tag), VECS[i].exp_st, VECS[i].exp_irq, VECS[i].exp_stall);
    end

    // R7: reserved positions alone, with every enable bit set
    drive('0, 1'b0, '0, 1'b1, 10'h3FF);
    drive('0, 1'b1, 10'h3FF, 1'b0, '0);
    drive(10'h009, 1'b0, '0, 1'b0, '0);
    check("R7", '0, 1'b0, 1'b0);

    // R9: byte-count flag alone leaves RX-full clear
    drive(10'h010, 1'b0, '0, 1'b0, '0);
    check("R9", 10'h010, 1'b1, 1'b1);
    drive(10'h100, 1'b0, '0, 1'b1, 10'h010);
    check("R9", 10'h100, 1'b1, 1'b1);

    // R1: reset mid-run clears status and enable
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1", '0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    drive(10'h200, 1'b0, '0, 1'b0, '0);
    check("R1", 10'h200, 1'b0, 1'b1);     // enable came back as zero

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule